// File: doc/BRIEF.md
# Strobed Parallel Bus Peripheral Decoder

This block sits behind a host-visible control byte that drives a byte-wide parallel bus toward a small terminal. The terminal carries a character LCD controller, a bank of eight LEDs and a scanned keypad. The host writes three values: a control byte holding the strobes, a 2-bit bus address and an outgoing data byte. The block watches successive control values for a qualified strobe falling edge. On each such edge it dispatches exactly one transfer to a sub-unit, and on reads it captures the result into a host-readable data-in register.

The control byte is not decoded bit by bit. A write transfer fires only when the OR of the active-low write strobe and the active-low chip select goes from nonzero to zero between the stored control value and the newly written one. A read transfer fires the same way, using the read strobe. Writes and reads use separate address maps. A power bit in the control byte latches a sticky power flag, and no transfer happens until that flag is set. The LCD controller and the keypad responder sit outside this block. It reaches them through a one-cycle LCD write pulse, a one-cycle LCD read request with a combinational reply, a scan-select register and a combinational keypad sense input.

Top module: `strobe_bus_decoder`

## Requirements
- R1: Synchronous active-high reset leaves `powered`=0, `led`=0x00, `scan_sel`=0xFF, `host_din`=0x00, both LCD strobes low and the stored control value at 0xFF.
- R2: A control write with bit 7 high sets `powered` one cycle later. `powered` then stays high until reset, even when bit 7 is written low. Transfers carried by that same write are already serviced.
- R3: While the power flag is clear and the current write does not set bit 7, no transfer takes place: `led`, `scan_sel` and `host_din` keep their values, and neither LCD strobe pulses.
- R4: The control byte layout is bit 0 read strobe, bit 1 write strobe, bit 6 chip select, all active low. A write edge is (bit1|bit6) being 1 in the stored value and 0 in the new value. A read edge uses (bit0|bit6) in the same way. A control write equal to the stored value is ignored and fires nothing.
- R5: On a write edge, address 1 loads `led` and address 3 loads `scan_sel` with the data byte. Both are visible one cycle after the control write.
- R6: On a write edge, address 0 raises `lcd_wr_stb` for exactly one cycle with `lcd_wr_rs`=0 (instruction). Address 2 does the same with `lcd_wr_rs`=1 (character data). In both cases `lcd_wr_byte` carries the data byte and the pulse starts one cycle after the control write.
- R7: On a read edge, address 0 loads `kbd_sense` into `host_din`. Address 1 pulses `lcd_rd_stb` with `lcd_rd_rs`=0 and loads `lcd_rd_byte`. Address 3 does the same with `lcd_rd_rs`=1. The request runs in the cycle after the control write, and `host_din` updates one cycle after that.
- R8: Address 2 on a read edge pulses no strobe and leaves `host_din` unchanged.
- R9: When a write edge and a read edge occur in the same control write, only the write is serviced.
- R10: `host_din` holds its value until the next serviced read. Write transfers do not alter it.
- R11: An address or data byte written in the same cycle as the control byte is the one the transfer uses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_ctrl_we | input | 1 | Write enable for the control byte |
| host_ctrl | input | 8 | New control byte |
| host_addr_we | input | 1 | Write enable for the bus address |
| host_addr | input | 2 | New bus address |
| host_dout_we | input | 1 | Write enable for the outgoing data byte |
| host_dout | input | 8 | New outgoing data byte |
| kbd_sense | input | 8 | Keypad response for the current scan selection (combinational) |
| lcd_rd_byte | input | 8 | LCD reply to a read request (combinational) |
| powered | output | 1 | Sticky power flag |
| led | output | 8 | LED latch |
| scan_sel | output | 8 | Keypad scan-select register |
| lcd_wr_stb | output | 1 | One-cycle LCD write pulse |
| lcd_wr_rs | output | 1 | LCD write target: 0 instruction, 1 data |
| lcd_wr_byte | output | 8 | LCD write byte |
| lcd_rd_stb | output | 1 | One-cycle LCD read request |
| lcd_rd_rs | output | 1 | LCD read source: 0 status, 1 data |
| host_din | output | 8 | Captured read result |

## Verification
Several control sequences are applied to the strobe decoder, and each one separates a different mistake. A write-strobe fall with chip select already low must be told apart from a change that leaves the qualifier high (read strobe toggled while chip select stays high). A rewrite of the unchanged value shows whether the stored-value update is skipped. A sequence in which the write and read qualifiers fall together shows whether the write-first priority holds. Every address is exercised on both maps, including the unused read address. The same transfers are then repeated before power-up, at the power-up write, and after a later reset, so that a missing or non-sticky power gate shows up.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  localparam int CTRL_W  = 8;
  localparam int RD_BIT  = 0;
  localparam int WR_BIT  = 1;
  localparam int CS_BIT  = 6;
  localparam int PWR_BIT = 7;

  typedef enum logic [1:0] {
    WA_LCD_CMD = 2'd0,
    WA_LED     = 2'd1,
    WA_LCD_DAT = 2'd2,
    WA_SCAN    = 2'd3
  } wr_dest_e;

  typedef enum logic [1:0] {
    RA_KEYS     = 2'd0,
    RA_LCD_STAT = 2'd1,
    RA_NONE     = 2'd2,
    RA_LCD_DAT  = 2'd3
  } rd_src_e;

  // Qualifier: strobe OR chip select (both active low) is nonzero.
  function automatic logic qual_high(input logic [CTRL_W-1:0] c, input int sb);
    return c[sb] | c[CS_BIT];
  endfunction

  // Qualifier goes from high in the old value to low in the new one.
  function automatic logic qual_falls(input logic [CTRL_W-1:0] old_c,
                                      input logic [CTRL_W-1:0] new_c,
                                      input int sb);
    return qual_high(old_c, sb) && !qual_high(new_c, sb);
  endfunction
endpackage

// File: rtl/sbd_ctrl_track.sv
module sbd_ctrl_track
  import sbd_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_in,
  output logic [CTRL_W-1:0] ctrl_cur,
  output logic [CTRL_W-1:0] ctrl_prev,
  output logic              powered,
  output logic              wr_fire,
  output logic              rd_fire
);
  logic accept, pwr_next, wr_edge, rd_edge;

  assign accept   = ctrl_we && (ctrl_in != ctrl_cur);
  assign pwr_next = powered | (accept & ctrl_in[PWR_BIT]);
  assign wr_edge  = accept && qual_falls(ctrl_cur, ctrl_in, WR_BIT);
  assign rd_edge  = accept && qual_falls(ctrl_cur, ctrl_in, RD_BIT);
  // Write wins when both qualifiers fall in one update.
  assign wr_fire  = pwr_next && wr_edge;
  assign rd_fire  = pwr_next && rd_edge && !wr_edge;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_cur  <= '1;
      ctrl_prev <= '1;
      powered   <= 1'b0;
    end else begin
      powered <= pwr_next;
      if (accept) begin
        ctrl_prev <= ctrl_cur;
        ctrl_cur  <= ctrl_in;
      end
    end
  end

  AST_PWR_STICKY: assert property (@(posedge clk) disable iff (rst)
    powered |=> powered); // R2

  AST_PREV_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && (ctrl_cur != $past(ctrl_cur))) |-> (ctrl_prev == $past(ctrl_cur))); // R4
endmodule

// File: rtl/sbd_wr_dispatch.sv
module sbd_wr_dispatch
  import sbd_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_fire,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] data,
  output logic [DW-1:0] led,
  output logic [DW-1:0] scan_sel,
  output logic          lcd_stb,
  output logic          lcd_rs,
  output logic [DW-1:0] lcd_byte
);
  wr_dest_e dest;
  assign dest = wr_dest_e'(addr[1:0]);

  always_ff @(posedge clk) begin
    if (rst) begin
      led      <= '0;
      scan_sel <= '1;
      lcd_stb  <= 1'b0;
      lcd_rs   <= 1'b0;
      lcd_byte <= '0;
    end else begin
      lcd_stb <= 1'b0;
      if (wr_fire) begin
        unique case (dest)
          WA_LED:  led      <= data;
          WA_SCAN: scan_sel <= data;
          WA_LCD_CMD, WA_LCD_DAT: begin
            lcd_stb  <= 1'b1;
            lcd_rs   <= (dest == WA_LCD_DAT);
            lcd_byte <= data;
          end
          default: ;
        endcase
      end
    end
  end

  AST_LCD_WR_PULSE: assert property (@(posedge clk) disable iff (rst)
    lcd_stb |=> !lcd_stb); // R6
endmodule

// File: rtl/sbd_rd_capture.sv
module sbd_rd_capture
  import sbd_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          rd_fire,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] kbd_sense,
  input  logic [DW-1:0] lcd_reply,
  output logic          lcd_req,
  output logic          lcd_req_rs,
  output logic [DW-1:0] din
);
  logic    pend;
  rd_src_e src;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend <= 1'b0;
      src  <= RA_NONE;
    end else begin
      pend <= rd_fire;
      if (rd_fire) src <= rd_src_e'(addr[1:0]);
    end
  end

  assign lcd_req    = pend && ((src == RA_LCD_STAT) || (src == RA_LCD_DAT));
  assign lcd_req_rs = (src == RA_LCD_DAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      din <= '0;
    end else if (pend) begin
      unique case (src)
        RA_KEYS:                 din <= kbd_sense;
        RA_LCD_STAT, RA_LCD_DAT: din <= lcd_reply;
        default: ;
      endcase
    end
  end

  AST_DIN_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(pend)) |-> $stable(din)); // R10

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    lcd_req |=> !lcd_req); // R7
endmodule

// File: rtl/strobe_bus_decoder.sv
module strobe_bus_decoder
  import sbd_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_ctrl_we,
  input  logic [7:0]    host_ctrl,
  input  logic          host_addr_we,
  input  logic [AW-1:0] host_addr,
  input  logic          host_dout_we,
  input  logic [DW-1:0] host_dout,
  input  logic [DW-1:0] kbd_sense,
  input  logic [DW-1:0] lcd_rd_byte,
  output logic          powered,
  output logic [DW-1:0] led,
  output logic [DW-1:0] scan_sel,
  output logic          lcd_wr_stb,
  output logic          lcd_wr_rs,
  output logic [DW-1:0] lcd_wr_byte,
  output logic          lcd_rd_stb,
  output logic          lcd_rd_rs,
  output logic [DW-1:0] host_din
);
  logic [AW-1:0]     addr_q, addr_eff;
  logic [DW-1:0]     dout_q, dout_eff;
  logic [CTRL_W-1:0] ctrl_cur, ctrl_prev;
  logic              wr_fire, rd_fire;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      dout_q <= '0;
    end else begin
      if (host_addr_we) addr_q <= host_addr;
      if (host_dout_we) dout_q <= host_dout;
    end
  end

  // Values written in the same cycle as the control byte take effect.
  assign addr_eff = host_addr_we ? host_addr : addr_q;
  assign dout_eff = host_dout_we ? host_dout : dout_q;

  sbd_ctrl_track u_track (
    .clk      (clk),
    .rst      (rst),
    .ctrl_we  (host_ctrl_we),
    .ctrl_in  (host_ctrl),
    .ctrl_cur (ctrl_cur),
    .ctrl_prev(ctrl_prev),
    .powered  (powered),
    .wr_fire  (wr_fire),
    .rd_fire  (rd_fire)
  );

  sbd_wr_dispatch #(.DW(DW), .AW(AW)) u_wr (
    .clk     (clk),
    .rst     (rst),
    .wr_fire (wr_fire),
    .addr    (addr_eff),
    .data    (dout_eff),
    .led     (led),
    .scan_sel(scan_sel),
    .lcd_stb (lcd_wr_stb),
    .lcd_rs  (lcd_wr_rs),
    .lcd_byte(lcd_wr_byte)
  );

  sbd_rd_capture #(.DW(DW), .AW(AW)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .rd_fire   (rd_fire),
    .addr      (addr_eff),
    .kbd_sense (kbd_sense),
    .lcd_reply (lcd_rd_byte),
    .lcd_req   (lcd_rd_stb),
    .lcd_req_rs(lcd_rd_rs),
    .din       (host_din)
  );

  AST_WR_OVER_RD: assert property (@(posedge clk) disable iff (rst)
    lcd_wr_stb |-> !lcd_rd_stb); // R9

  AST_GATED_BY_PWR: assert property (@(posedge clk) disable iff (rst)
    (lcd_wr_stb || lcd_rd_stb) |-> powered); // R3
endmodule

// File: tb/sim_strobe_bus_decoder.sv
module sim_strobe_bus_decoder;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       host_ctrl_we = 1'b0, host_addr_we = 1'b0, host_dout_we = 1'b0;
  logic [7:0] host_ctrl = 8'hFF;
  logic [1:0] host_addr = 2'd0;
  logic [7:0] host_dout = 8'h00;
  logic [7:0] kbd_sense = 8'hF3;
  logic [7:0] lcd_rd_byte;
  logic       powered, lcd_wr_stb, lcd_wr_rs, lcd_rd_stb, lcd_rd_rs;
  logic [7:0] led, scan_sel, lcd_wr_byte, host_din;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  // Bench model of the LCD reply: status 0x3C, character data 0xA5.
  assign lcd_rd_byte = lcd_rd_rs ? 8'hA5 : 8'h3C;

  strobe_bus_decoder u0 (
    .clk(clk), .rst(rst),
    .host_ctrl_we(host_ctrl_we), .host_ctrl(host_ctrl),
    .host_addr_we(host_addr_we), .host_addr(host_addr),
    .host_dout_we(host_dout_we), .host_dout(host_dout),
    .kbd_sense(kbd_sense), .lcd_rd_byte(lcd_rd_byte),
    .powered(powered), .led(led), .scan_sel(scan_sel),
    .lcd_wr_stb(lcd_wr_stb), .lcd_wr_rs(lcd_wr_rs), .lcd_wr_byte(lcd_wr_byte),
    .lcd_rd_stb(lcd_rd_stb), .lcd_rd_rs(lcd_rd_rs), .host_din(host_din)
  );

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic set_addr_data(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    host_addr = a; host_addr_we = 1'b1;
    host_dout = d; host_dout_we = 1'b1;
    @(negedge clk);
    host_addr_we = 1'b0; host_dout_we = 1'b0;
  endtask

  // Returns at the negedge after the control write has been clocked in.
  task automatic wr_ctrl(input logic [7:0] v);
    @(negedge clk);
    host_ctrl = v; host_ctrl_we = 1'b1;
    @(negedge clk);
    host_ctrl_we = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset_state();
    chk("R1 powered", {7'd0, powered}, 8'h00);
    chk("R1 led", led, 8'h00);
    chk("R1 scan_sel", scan_sel, 8'hFF);
    chk("R1 host_din", host_din, 8'h00);
    chk("R1 strobes", {6'd0, lcd_wr_stb, lcd_rd_stb}, 8'h00);
  endtask

  task automatic t_unpowered();
    set_addr_data(2'd1, 8'h55);
    wr_ctrl(8'h3D);                       // write qualifier falls, no power
    chk("R3 led unchanged", led, 8'h00);
    chk("R3 no lcd write", {7'd0, lcd_wr_stb}, 8'h00);
    chk("R3 powered low", {7'd0, powered}, 8'h00);
    wr_ctrl(8'h7F);
    set_addr_data(2'd1, 8'h66);
    wr_ctrl(8'h3E);                       // read qualifier falls, no power
    @(negedge clk);
    chk("R3 din unchanged", host_din, 8'h00);
    wr_ctrl(8'h7F);
  endtask

  task automatic t_power_on();
    set_addr_data(2'd1, 8'hA5);
    wr_ctrl(8'hBD);                       // power bit plus write fall
    chk("R2 powered set", {7'd0, powered}, 8'h01);
    chk("R2 R5 led loaded on power write", led, 8'hA5);
    wr_ctrl(8'h7F);
    chk("R2 powered sticky", {7'd0, powered}, 8'h01);
  endtask

  task automatic t_edge_rules();
    set_addr_data(2'd1, 8'h11);
    wr_ctrl(8'h3F);                       // bit6 low but write strobe high
    chk("R4 no fire while strobe high", led, 8'hA5);
    wr_ctrl(8'h7F);
    wr_ctrl(8'h7D);                       // strobe low, chip select high
    chk("R4 no fire while cs high", led, 8'hA5);
    wr_ctrl(8'h3D);                       // now the qualifier falls
    chk("R4 fire on qualifier fall", led, 8'h11);
    set_addr_data(2'd1, 8'h33);
    wr_ctrl(8'h3D);                       // same value rewritten
    chk("R4 same value ignored", led, 8'h11);
    wr_ctrl(8'h7F);
  endtask

  task automatic t_writes();
    set_addr_data(2'd3, 8'hFE);
    wr_ctrl(8'h3D);
    chk("R5 scan_sel loaded", scan_sel, 8'hFE);
    wr_ctrl(8'h7F);
    set_addr_data(2'd0, 8'h01);
    wr_ctrl(8'h3D);
    chk("R6 cmd strobe", {7'd0, lcd_wr_stb}, 8'h01);
    chk("R6 cmd rs", {7'd0, lcd_wr_rs}, 8'h00);
    chk("R6 cmd byte", lcd_wr_byte, 8'h01);
    @(negedge clk);
    chk("R6 strobe one cycle", {7'd0, lcd_wr_stb}, 8'h00);
    wr_ctrl(8'h7F);
    // Address, data and control written in one cycle.
    @(negedge clk);
    host_addr = 2'd2; host_addr_we = 1'b1;
    host_dout = 8'h48; host_dout_we = 1'b1;
    host_ctrl = 8'h3D; host_ctrl_we = 1'b1;
    @(negedge clk);
    host_addr_we = 1'b0; host_dout_we = 1'b0; host_ctrl_we = 1'b0;
    chk("R11 R6 data strobe", {7'd0, lcd_wr_stb}, 8'h01);
    chk("R11 R6 data rs", {7'd0, lcd_wr_rs}, 8'h01);
    chk("R11 R6 data byte", lcd_wr_byte, 8'h48);
    wr_ctrl(8'h7F);
  endtask

  task automatic t_reads();
    set_addr_data(2'd0, 8'h00);
    wr_ctrl(8'h3E);
    chk("R7 keys no lcd req", {7'd0, lcd_rd_stb}, 8'h00);
    @(negedge clk);
    chk("R7 keys captured", host_din, 8'hF3);
    wr_ctrl(8'h7F);
    set_addr_data(2'd1, 8'h00);
    wr_ctrl(8'h3E);
    chk("R7 status req", {6'd0, lcd_rd_stb, lcd_rd_rs}, 8'h02);
    @(negedge clk);
    chk("R7 status captured", host_din, 8'h3C);
    wr_ctrl(8'h7F);
    set_addr_data(2'd3, 8'h00);
    wr_ctrl(8'h3E);
    chk("R7 data req", {6'd0, lcd_rd_stb, lcd_rd_rs}, 8'h03);
    @(negedge clk);
    chk("R7 data captured", host_din, 8'hA5);
    wr_ctrl(8'h7F);
    set_addr_data(2'd2, 8'h00);
    wr_ctrl(8'h3E);
    chk("R8 no req on addr 2", {7'd0, lcd_rd_stb}, 8'h00);
    @(negedge clk);
    chk("R8 din kept on addr 2", host_din, 8'hA5);
    wr_ctrl(8'h7F);
    set_addr_data(2'd1, 8'h77);
    wr_ctrl(8'h3D);
    @(negedge clk);
    chk("R10 write leaves din", host_din, 8'hA5);
    chk("R10 write took effect", led, 8'h77);
    wr_ctrl(8'h7F);
  endtask

  task automatic t_priority();
    set_addr_data(2'd1, 8'h99);
    wr_ctrl(8'h3C);                       // both qualifiers fall
    chk("R9 write serviced", led, 8'h99);
    chk("R9 no read req", {7'd0, lcd_rd_stb}, 8'h00);
    @(negedge clk);
    chk("R9 din unchanged", host_din, 8'hA5);
    wr_ctrl(8'h7F);
  endtask

  task automatic t_reset_again();
    do_reset();
    chk("R1 powered cleared", {7'd0, powered}, 8'h00);
    chk("R1 led cleared", led, 8'h00);
    chk("R1 scan_sel set", scan_sel, 8'hFF);
    chk("R1 din cleared", host_din, 8'h00);
    set_addr_data(2'd1, 8'h42);
    wr_ctrl(8'h3D);                       // stored value is 0xFF again
    chk("R3 gated after reset", led, 8'h00);
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_unpowered();
    t_power_on();
    t_edge_rules();
    t_writes();
    t_reads();
    t_priority();
    t_reset_again();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule